// File: doc/BRIEF.md
# Rename-Group Move Elimination Resolver

This block sits behind the per-slot rename-table lookups of a multi-wide rename stage. Every cycle it receives a group of `RENAME_W` instructions together with their logical operands, the physical registers read from the rename table and the freshly allocated physical destinations. It repairs the physical sources and the previous physical destination of each slot for read-after-write and write-after-write dependencies inside the group. In the same pass it removes the wait on register-copy instructions. When slot i reads the register that a copy in slot i-1 has just written, it is pointed straight at the physical register the copy reads, so it need not wait on the copy's result.

Copy recognition uses only the 32-bit instruction word: an add-immediate with a zero immediate. Elimination can be switched off through a one-bit control register in a small CSR write port. The resolver sees that bit through one extra register stage. All outputs are registered, so a group presented before a clock edge appears on the outputs after that edge.

Top module: `rn_move_resolver`

## Requirements
- R1: A word is a register copy when bits [31:20] are all zero, bits [14:12] are 000 and bits [6:0] are 0010011, whatever bits [19:15] and [11:7] hold. Any other word, for example a nonzero immediate, a nonzero bits [14:12] or another opcode, is not a copy.
- R2: A source of slot i uses the physical destination of the highest-numbered valid earlier slot j<i whose destination class equals the source's class and whose logical destination equals the source's index. Classes are coded 0 none, 1 integer, 2 floating point. With no such slot, the rename-table value passes through. A destination class of 0 never matches.
- R3: The previous physical destination of slot i follows the rule of R2, with slot i's own destination class and logical destination as the query.
- R4: An invalid slot never supplies a bypass value and never acts as the producer of an elimination.
- R5: Source 1 (or source 2) of slot i≥1 is eliminated when all of these hold: both slots are valid, slot i-1 is a copy per R1, slot i-1's logical destination is nonzero, the source's class is integer (1), its index equals slot i-1's logical destination, and elimination is enabled. The source then takes slot i-1's final physical source 1, and the slot's matching flag is 1.
- R6: Source 3 and the previous destination never use elimination. The two flags of slot 0 are always 0, and the flags of any slot are 0 whenever R5 does not hold.
- R7: Slot i-1's final physical source 1 already includes its own bypass or elimination, so a chain of back-to-back copies resolves to the register read by the first copy of the chain.
- R8: A copy whose logical destination is register 0 never causes elimination, although it still bypasses under R2.
- R9: The enable bit resets to 1. A write to CSR address 0x5C4 sets it to bit 0 of the write data. Writes to any other address leave it unchanged. With the bit at 0, sources resolve by R2 alone and both flags stay 0.
- R10: A CSR write captured at clock edge k first affects the group captured at edge k+2. The group captured at edge k+1 still uses the previous setting.
- R11: Outputs are registered: the result for the group presented before an edge appears after that edge, and the valid bits pass through unchanged. A synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR write address |
| csr_wdata | input | 64 | CSR write data |
| in_valid | input | RENAME_W | Slot valid bits |
| in_instr | input | RENAME_W x 32 | Instruction words |
| in_lsrc1 | input | RENAME_W x LREG_W | Logical source 1 |
| in_lsrc2 | input | RENAME_W x LREG_W | Logical source 2 |
| in_lsrc3 | input | RENAME_W x LREG_W | Logical source 3 |
| in_src1_cls | input | RENAME_W x 2 | Source 1 class (0 none, 1 int, 2 fp) |
| in_src2_cls | input | RENAME_W x 2 | Source 2 class |
| in_src3_cls | input | RENAME_W x 2 | Source 3 class |
| in_ldest | input | RENAME_W x LREG_W | Logical destination |
| in_dest_cls | input | RENAME_W x 2 | Destination class |
| in_tab_psrc1 | input | RENAME_W x PREG_W | Table value for source 1 |
| in_tab_psrc2 | input | RENAME_W x PREG_W | Table value for source 2 |
| in_tab_psrc3 | input | RENAME_W x PREG_W | Table value for source 3 |
| in_tab_old_pdest | input | RENAME_W x PREG_W | Table value for the previous destination |
| in_pdest | input | RENAME_W x PREG_W | Newly allocated physical destination |
| out_valid | output | RENAME_W | Registered valid bits |
| out_psrc1 | output | RENAME_W x PREG_W | Resolved physical source 1 |
| out_psrc2 | output | RENAME_W x PREG_W | Resolved physical source 2 |
| out_psrc3 | output | RENAME_W x PREG_W | Resolved physical source 3 |
| out_old_pdest | output | RENAME_W x PREG_W | Resolved previous physical destination |
| out_src1_elim | output | RENAME_W | Source 1 eliminated |
| out_src2_elim | output | RENAME_W | Source 2 eliminated |

## Verification
The hardest case to reach is a chain: a copy in slot i-1 that is itself eliminated against a copy in slot i-2. The consumer in slot i must then inherit a value that went through two substitutions, and this only shows when every link matches on index, class and validity at the same time. Directed groups build chains of three copies and copies writing register 0. A random sweep draws logical indices from only four registers and makes about a third of the words copies, so chains, invalid links and near-miss words occur often. The enable switch is also driven on the exact cycle boundary where the old and new settings apply to consecutive groups.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_INT  = 2'd1,
    RC_FP   = 2'd2
  } rclass_e;

  localparam logic [6:0]  OPC_OP_IMM = 7'b0010011;
  localparam logic [2:0]  F3_ADDI    = 3'b000;
  localparam logic [11:0] IMM_ZERO   = 12'h000;
endpackage

// File: rtl/rn_move_detect.sv
module rn_move_detect
  import rn_pkg::*;
(
  input  logic [31:0] instr,
  output logic        is_move
);
  // register fields are don't-care for recognition
  logic unused_fields;
  assign unused_fields = ^{instr[19:15], instr[11:7]};

  assign is_move = (instr[31:20] == IMM_ZERO) &&
                   (instr[14:12] == F3_ADDI)  &&
                   (instr[6:0]   == OPC_OP_IMM);
endmodule

// File: rtl/rn_raw_bypass.sv
module rn_raw_bypass
  import rn_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int PREG_W = 7,
  parameter int LREG_W = 5
) (
  input  logic [SLOTS-1:0]             prod_valid,
  input  logic [SLOTS-1:0][1:0]        prod_cls,
  input  logic [SLOTS-1:0][LREG_W-1:0] prod_ldest,
  input  logic [SLOTS-1:0][PREG_W-1:0] prod_pdest,
  input  logic [SLOTS-1:0][1:0]        q_cls,
  input  logic [SLOTS-1:0][LREG_W-1:0] q_idx,
  input  logic [SLOTS-1:0][PREG_W-1:0] q_table,
  output logic [SLOTS-1:0][PREG_W-1:0] q_res
);
  // last slot never produces for a later slot; slot 0 never queries
  logic unused_edges;
  assign unused_edges = ^{prod_valid[SLOTS-1], prod_cls[SLOTS-1],
                          prod_ldest[SLOTS-1], prod_pdest[SLOTS-1],
                          q_cls[0], q_idx[0]};

  // scan producers oldest to youngest so the latest match wins
  always_comb begin
    q_res = q_table;
    for (int i = 1; i < SLOTS; i++) begin
      for (int j = 0; j < i; j++) begin
        if (prod_valid[j] && (prod_cls[j] != RC_NONE) &&
            (prod_cls[j] == q_cls[i]) && (prod_ldest[j] == q_idx[i]))
          q_res[i] = prod_pdest[j];
      end
    end
  end
endmodule

// File: rtl/rn_enable_csr.sv
module rn_enable_csr #(
  parameter int          XLEN     = 64,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] CTL_ADDR = 12'h5C4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  output logic              enable
);
  logic ctl_q;
  logic en_q;
  logic hit;

  logic unused_hi;
  assign unused_hi = ^wr_data[XLEN-1:1];

  assign hit = wr_en && (wr_addr == ADDR_W'(CTL_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= 1'b1;
      en_q  <= 1'b1;
    end else begin
      if (hit) ctl_q <= wr_data[0];
      en_q <= ctl_q;
    end
  end

  assign enable = en_q;

  a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(CTL_ADDR)) |=> (ctl_q == $past(wr_data[0])));

  a_r9_other_addr_kept: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_W'(CTL_ADDR)) |=> $stable(ctl_q));
endmodule

// File: rtl/rn_move_resolver.sv
module rn_move_resolver
  import rn_pkg::*;
#(
  parameter int          RENAME_W = 4,
  parameter int          PREG_W   = 7,
  parameter int          LREG_W   = 5,
  parameter int          XLEN     = 64,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] CTL_ADDR = 12'h5C4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                csr_we,
  input  logic [ADDR_W-1:0]                   csr_addr,
  input  logic [XLEN-1:0]                     csr_wdata,
  input  logic [RENAME_W-1:0]                 in_valid,
  input  logic [RENAME_W-1:0][31:0]           in_instr,
  input  logic [RENAME_W-1:0][LREG_W-1:0]     in_lsrc1,
  input  logic [RENAME_W-1:0][LREG_W-1:0]     in_lsrc2,
  input  logic [RENAME_W-1:0][LREG_W-1:0]     in_lsrc3,
  input  logic [RENAME_W-1:0][1:0]            in_src1_cls,
  input  logic [RENAME_W-1:0][1:0]            in_src2_cls,
  input  logic [RENAME_W-1:0][1:0]            in_src3_cls,
  input  logic [RENAME_W-1:0][LREG_W-1:0]     in_ldest,
  input  logic [RENAME_W-1:0][1:0]            in_dest_cls,
  input  logic [RENAME_W-1:0][PREG_W-1:0]     in_tab_psrc1,
  input  logic [RENAME_W-1:0][PREG_W-1:0]     in_tab_psrc2,
  input  logic [RENAME_W-1:0][PREG_W-1:0]     in_tab_psrc3,
  input  logic [RENAME_W-1:0][PREG_W-1:0]     in_tab_old_pdest,
  input  logic [RENAME_W-1:0][PREG_W-1:0]     in_pdest,
  output logic [RENAME_W-1:0]                 out_valid,
  output logic [RENAME_W-1:0][PREG_W-1:0]     out_psrc1,
  output logic [RENAME_W-1:0][PREG_W-1:0]     out_psrc2,
  output logic [RENAME_W-1:0][PREG_W-1:0]     out_psrc3,
  output logic [RENAME_W-1:0][PREG_W-1:0]     out_old_pdest,
  output logic [RENAME_W-1:0]                 out_src1_elim,
  output logic [RENAME_W-1:0]                 out_src2_elim
);
  localparam int PRODS = RENAME_W - 1;

  logic en_q;

  rn_enable_csr #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)
  ) u_csr (
    .clk(clk), .rst(rst), .wr_en(csr_we), .wr_addr(csr_addr),
    .wr_data(csr_wdata), .enable(en_q)
  );

  // copy detection only for slots that can precede another slot
  logic [PRODS-1:0] prod_move;
  logic unused_last;
  assign unused_last = ^in_instr[RENAME_W-1];

  for (genvar p = 0; p < PRODS; p++) begin : g_det
    rn_move_detect u_det (.instr(in_instr[p]), .is_move(prod_move[p]));
  end

  // intra-group dependency resolution, one chain per operand
  logic [RENAME_W-1:0][PREG_W-1:0] byp1, byp2, byp3, bypo;

  rn_raw_bypass #(.SLOTS(RENAME_W), .PREG_W(PREG_W), .LREG_W(LREG_W)) u_byp1 (
    .prod_valid(in_valid), .prod_cls(in_dest_cls), .prod_ldest(in_ldest),
    .prod_pdest(in_pdest), .q_cls(in_src1_cls), .q_idx(in_lsrc1),
    .q_table(in_tab_psrc1), .q_res(byp1));

  rn_raw_bypass #(.SLOTS(RENAME_W), .PREG_W(PREG_W), .LREG_W(LREG_W)) u_byp2 (
    .prod_valid(in_valid), .prod_cls(in_dest_cls), .prod_ldest(in_ldest),
    .prod_pdest(in_pdest), .q_cls(in_src2_cls), .q_idx(in_lsrc2),
    .q_table(in_tab_psrc2), .q_res(byp2));

  rn_raw_bypass #(.SLOTS(RENAME_W), .PREG_W(PREG_W), .LREG_W(LREG_W)) u_byp3 (
    .prod_valid(in_valid), .prod_cls(in_dest_cls), .prod_ldest(in_ldest),
    .prod_pdest(in_pdest), .q_cls(in_src3_cls), .q_idx(in_lsrc3),
    .q_table(in_tab_psrc3), .q_res(byp3));

  rn_raw_bypass #(.SLOTS(RENAME_W), .PREG_W(PREG_W), .LREG_W(LREG_W)) u_bypo (
    .prod_valid(in_valid), .prod_cls(in_dest_cls), .prod_ldest(in_ldest),
    .prod_pdest(in_pdest), .q_cls(in_dest_cls), .q_idx(in_ldest),
    .q_table(in_tab_old_pdest), .q_res(bypo));

  // producer side of elimination: valid pair, copy, nonzero target, enabled
  logic [RENAME_W-1:0] pair_ok;
  assign pair_ok[0] = 1'b0;
  for (genvar s = 1; s < RENAME_W; s++) begin : g_pair
    assign pair_ok[s] = in_valid[s] && in_valid[s-1] && prod_move[s-1] &&
                        (in_ldest[s-1] != '0) && en_q;
  end

  // elimination walks slots in order so chains of copies collapse
  logic [RENAME_W-1:0][PREG_W-1:0] res1, res2;
  logic [RENAME_W-1:0]             el1, el2;

  always_comb begin
    res1 = byp1;
    res2 = byp2;
    el1  = '0;
    el2  = '0;
    for (int i = 1; i < RENAME_W; i++) begin
      el1[i] = pair_ok[i] && (in_src1_cls[i] == RC_INT) &&
               (in_lsrc1[i] == in_ldest[i-1]);
      el2[i] = pair_ok[i] && (in_src2_cls[i] == RC_INT) &&
               (in_lsrc2[i] == in_ldest[i-1]);
      if (el1[i]) res1[i] = res1[i-1];
      if (el2[i]) res2[i] = res1[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= '0;
      out_psrc1     <= '0;
      out_psrc2     <= '0;
      out_psrc3     <= '0;
      out_old_pdest <= '0;
      out_src1_elim <= '0;
      out_src2_elim <= '0;
    end else begin
      out_valid     <= in_valid;
      out_psrc1     <= res1;
      out_psrc2     <= res2;
      out_psrc3     <= byp3;
      out_old_pdest <= bypo;
      out_src1_elim <= el1;
      out_src2_elim <= el2;
    end
  end

  a_r11_valid_passes: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  for (genvar s = 1; s < RENAME_W; s++) begin : g_chk
    a_r5_src1_takes_prev: assert property (@(posedge clk) disable iff (rst)
      out_src1_elim[s] |-> (out_psrc1[s] == out_psrc1[s-1]));

    a_r5_src2_takes_prev: assert property (@(posedge clk) disable iff (rst)
      out_src2_elim[s] |-> (out_psrc2[s] == out_psrc1[s-1]));

    a_r4_elim_needs_valid: assert property (@(posedge clk) disable iff (rst)
      (out_src1_elim[s] || out_src2_elim[s]) |-> (out_valid[s] && out_valid[s-1]));

    a_r9_elim_needs_enable: assert property (@(posedge clk) disable iff (rst)
      (out_src1_elim[s] || out_src2_elim[s]) |-> $past(en_q));
  end
endmodule

// File: tb/rn_move_resolver_tb.sv
module rn_move_resolver_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 4;
  localparam int PW    = 7;
  localparam int LW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [W-1:0]          in_valid = '0;
  logic [W-1:0][31:0]    in_instr = '0;
  logic [W-1:0][LW-1:0]  in_lsrc1 = '0, in_lsrc2 = '0, in_lsrc3 = '0, in_ldest = '0;
  logic [W-1:0][1:0]     in_src1_cls = '0, in_src2_cls = '0, in_src3_cls = '0, in_dest_cls = '0;
  logic [W-1:0][PW-1:0]  in_tab_psrc1 = '0, in_tab_psrc2 = '0, in_tab_psrc3 = '0;
  logic [W-1:0][PW-1:0]  in_tab_old_pdest = '0, in_pdest = '0;
  logic [W-1:0]          out_valid, out_src1_elim, out_src2_elim;
  logic [W-1:0][PW-1:0]  out_psrc1, out_psrc2, out_psrc3, out_old_pdest;

  logic [W-1:0][PW-1:0]  exp_p1, exp_p2, exp_p3, exp_old;
  logic [W-1:0]          exp_e1, exp_e2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rn_move_resolver #(.RENAME_W(W), .PREG_W(PW), .LREG_W(LW)) dut_i (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .in_valid(in_valid), .in_instr(in_instr),
    .in_lsrc1(in_lsrc1), .in_lsrc2(in_lsrc2), .in_lsrc3(in_lsrc3),
    .in_src1_cls(in_src1_cls), .in_src2_cls(in_src2_cls), .in_src3_cls(in_src3_cls),
    .in_ldest(in_ldest), .in_dest_cls(in_dest_cls),
    .in_tab_psrc1(in_tab_psrc1), .in_tab_psrc2(in_tab_psrc2), .in_tab_psrc3(in_tab_psrc3),
    .in_tab_old_pdest(in_tab_old_pdest), .in_pdest(in_pdest),
    .out_valid(out_valid), .out_psrc1(out_psrc1), .out_psrc2(out_psrc2),
    .out_psrc3(out_psrc3), .out_old_pdest(out_old_pdest),
    .out_src1_elim(out_src1_elim), .out_src2_elim(out_src2_elim));

  function automatic logic [31:0] mk_mv(input int rd, input int rs);
    return {12'h000, 5'(rs), 3'b000, 5'(rd), 7'b0010011};
  endfunction

  function automatic logic [31:0] mk_add(input int rd, input int rs1, input int rs2);
    return {7'h00, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
  endfunction

  function automatic bit is_copy(input logic [31:0] w);
    return (w[31:20] == 12'h0) && (w[14:12] == 3'b000) && (w[6:0] == 7'b0010011);
  endfunction

  function automatic logic [PW-1:0] lookup(input int i, input logic [1:0] c,
                                           input logic [LW-1:0] l, input logic [PW-1:0] t);
    logic [PW-1:0] r = t;
    for (int j = 0; j < i; j++)
      if (in_valid[j] && in_dest_cls[j] != 2'd0 && in_dest_cls[j] == c && in_ldest[j] == l)
        r = in_pdest[j];
    return r;
  endfunction

  // sequential reference model of the requirements
  task automatic model(input bit en_m);
    for (int i = 0; i < W; i++) begin
      logic [PW-1:0] b1, b2;
      bit ok;
      b1 = lookup(i, in_src1_cls[i], in_lsrc1[i], in_tab_psrc1[i]);
      b2 = lookup(i, in_src2_cls[i], in_lsrc2[i], in_tab_psrc2[i]);
      exp_p3[i]  = lookup(i, in_src3_cls[i], in_lsrc3[i], in_tab_psrc3[i]);
      exp_old[i] = lookup(i, in_dest_cls[i], in_ldest[i], in_tab_old_pdest[i]);
      ok = (i > 0) && en_m && in_valid[i] && in_valid[i-1] &&
           is_copy(in_instr[i-1]) && in_ldest[i-1] != 0;
      exp_e1[i] = ok && in_src1_cls[i] == 2'd1 && in_lsrc1[i] == in_ldest[i-1];
      exp_e2[i] = ok && in_src2_cls[i] == 2'd1 && in_lsrc2[i] == in_ldest[i-1];
      exp_p1[i] = exp_e1[i] ? exp_p1[i-1] : b1;
      exp_p2[i] = exp_e2[i] ? exp_p1[i-1] : b2;
    end
  endtask

  task automatic chk(input string tag, input int slot, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s slot %0d: actual=%0h expected=%0h", tag, slot, act, expv);
    end
  endtask

  // inputs are set at a falling edge; the result is read at the next one
  task automatic apply(input bit en_m, input string tag);
    model(en_m);
    @(negedge clk);
    for (int i = 0; i < W; i++) begin
      chk({tag, " R11 valid"}, i, 32'(out_valid[i]), 32'(in_valid[i]));
      chk({tag, " R2 R5 psrc1"}, i, 32'(out_psrc1[i]), 32'(exp_p1[i]));
      chk({tag, " R2 R5 psrc2"}, i, 32'(out_psrc2[i]), 32'(exp_p2[i]));
      chk({tag, " R6 psrc3"}, i, 32'(out_psrc3[i]), 32'(exp_p3[i]));
      chk({tag, " R3 old_pdest"}, i, 32'(out_old_pdest[i]), 32'(exp_old[i]));
      chk({tag, " R5 flag1"}, i, 32'(out_src1_elim[i]), 32'(exp_e1[i]));
      chk({tag, " R6 flag2"}, i, 32'(out_src2_elim[i]), 32'(exp_e2[i]));
    end
  endtask

  task automatic set_slot(input int i, input bit v, input logic [31:0] w,
                          input int ld, input int dc, input int l1, input int c1,
                          input int l2, input int c2, input int l3, input int c3);
    in_valid[i] = v;       in_instr[i] = w;
    in_ldest[i] = LW'(ld); in_dest_cls[i] = 2'(dc);
    in_lsrc1[i] = LW'(l1); in_src1_cls[i] = 2'(c1);
    in_lsrc2[i] = LW'(l2); in_src2_cls[i] = 2'(c2);
    in_lsrc3[i] = LW'(l3); in_src3_cls[i] = 2'(c3);
    in_tab_psrc1[i] = PW'(8*i + 1);  in_tab_psrc2[i] = PW'(8*i + 2);
    in_tab_psrc3[i] = PW'(8*i + 3);  in_tab_old_pdest[i] = PW'(8*i + 4);
    in_pdest[i] = PW'(64 + 8*i);
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  // copy then consumer reading the copy's target on sources 1 and 2
  task automatic grp_basic(input bit v0);
    set_slot(0, v0, mk_mv(1, 2), 1, 1, 2, 1, 0, 0, 0, 0);
    set_slot(1, 1, mk_add(5, 1, 1), 5, 1, 1, 1, 1, 1, 1, 1);
    set_slot(2, 1, mk_add(6, 5, 1), 6, 1, 5, 1, 1, 1, 0, 0);
    set_slot(3, 1, 32'h0000_1053, 1, 2, 1, 2, 6, 1, 1, 2);
  endtask

  task automatic gen_group();
    for (int i = 0; i < W; i++) begin
      int kind = $urandom_range(5);
      int ld = $urandom_range(3);
      logic [31:0] w = $urandom;
      in_valid[i] = ($urandom_range(7) != 0);
      in_lsrc1[i] = LW'($urandom_range(3)); in_src1_cls[i] = 2'($urandom_range(3));
      in_lsrc2[i] = LW'($urandom_range(3)); in_src2_cls[i] = 2'($urandom_range(3));
      in_lsrc3[i] = LW'($urandom_range(3)); in_src3_cls[i] = 2'($urandom_range(3));
      if (kind < 2) begin
        in_instr[i] = mk_mv(ld, int'(in_lsrc1[i]));
        in_dest_cls[i] = 2'd1; in_src1_cls[i] = 2'd1; in_src2_cls[i] = 2'd0;
      end else begin
        case (kind)
          2: w = {12'($urandom_range(4095, 1)), w[19:15], 3'b000, w[11:7], 7'b0010011};
          3: w = {12'h000, w[19:15], 3'($urandom_range(7, 1)), w[11:7], 7'b0010011};
          default: w[6:0] = 7'b0110011;
        endcase
        in_instr[i] = w;
        in_dest_cls[i] = 2'($urandom_range(2));
      end
      in_ldest[i] = LW'(ld);
      in_tab_psrc1[i] = PW'($urandom); in_tab_psrc2[i] = PW'($urandom);
      in_tab_psrc3[i] = PW'($urandom); in_tab_old_pdest[i] = PW'($urandom);
      in_pdest[i] = PW'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    // R11: reset clears outputs
    repeat (3) @(negedge clk);
    chk("R11 reset valid", 0, 32'(out_valid), 32'h0);
    chk("R11 reset psrc1", 0, 32'(out_psrc1), 32'h0);
    chk("R11 reset flags", 0, 32'({out_src1_elim, out_src2_elim}), 32'h0);
    rst = 1'b0;

    // R5: enable resets to 1, copy in slot 0 feeds slot 1 directly
    grp_basic(1'b1);
    apply(1'b1, "basic");
    chk("R5 src1 gets copy source", 1, 32'(out_psrc1[1]), 32'd1);
    chk("R5 src2 gets copy source", 1, 32'(out_psrc2[1]), 32'd1);
    chk("R6 src3 bypasses to copy pdest", 1, 32'(out_psrc3[1]), 32'd64);
    chk("R6 slot0 flags clear", 0, 32'({out_src1_elim[0], out_src2_elim[0]}), 32'h0);

    // R4: invalid copy neither bypasses nor eliminates
    grp_basic(1'b0);
    apply(1'b1, "invalid producer");
    chk("R4 no elim from invalid slot", 1, 32'(out_src1_elim[1]), 32'h0);
    chk("R4 table value kept", 1, 32'(out_psrc1[1]), 32'd9);

    // R7: chain of three copies collapses to the first copy's source
    set_slot(0, 1, mk_mv(1, 2), 1, 1, 2, 1, 0, 0, 0, 0);
    set_slot(1, 1, mk_mv(3, 1), 3, 1, 1, 1, 0, 0, 0, 0);
    set_slot(2, 1, mk_mv(4, 3), 4, 1, 3, 1, 0, 0, 0, 0);
    set_slot(3, 1, mk_add(7, 4, 4), 7, 1, 4, 1, 4, 1, 3, 1);
    apply(1'b1, "chain");
    chk("R7 chain end src1", 3, 32'(out_psrc1[3]), 32'd1);
    chk("R7 chain end src2", 3, 32'(out_psrc2[3]), 32'd1);

    // R8: copy writing register 0 only bypasses
    set_slot(0, 1, mk_mv(0, 2), 0, 1, 2, 1, 0, 0, 0, 0);
    set_slot(1, 1, mk_add(5, 0, 0), 5, 1, 0, 1, 0, 1, 0, 0);
    apply(1'b1, "x0 copy");
    chk("R8 no elim on x0", 1, 32'(out_src1_elim[1]), 32'h0);
    chk("R8 bypass from x0 copy", 1, 32'(out_psrc1[1]), 32'd64);

    // R1: near-miss words are not copies
    grp_basic(1'b1);
    in_instr[0] = {12'h001, 5'd2, 3'b000, 5'd1, 7'b0010011};
    apply(1'b1, "R1 imm nonzero");
    chk("R1 imm nonzero no elim", 1, 32'(out_src1_elim[1]), 32'h0);
    in_instr[0] = {12'h000, 5'd2, 3'b100, 5'd1, 7'b0010011};
    apply(1'b1, "R1 funct nonzero");
    in_instr[0] = {12'h000, 5'd2, 3'b000, 5'd1, 7'b0110011};
    apply(1'b1, "R1 other opcode");
    in_instr[0] = {12'h000, 5'd31, 3'b000, 5'd1, 7'b0010011};
    apply(1'b1, "R1 rs1 dont care");
    chk("R1 rs1 field ignored", 1, 32'(out_src1_elim[1]), 32'h1);

    // R10: group right after a write still uses the old setting
    csr_write(12'h5C4, 64'h0);
    grp_basic(1'b1);
    apply(1'b1, "R10 old setting");
    chk("R10 old enable still active", 1, 32'(out_src1_elim[1]), 32'h1);
    apply(1'b0, "R10 new setting");
    chk("R9 disabled no elim", 1, 32'(out_src1_elim[1]), 32'h0);

    // R9: other address ignored, then re-enable via bit 0
    csr_write(12'h5C3, 64'h1);
    repeat (2) @(negedge clk);
    grp_basic(1'b1);
    apply(1'b0, "R9 wrong address");
    chk("R9 wrong address ignored", 1, 32'(out_src1_elim[1]), 32'h0);
    csr_write(12'h5C4, 64'hFFFF_FFFF_FFFF_FFF1);
    repeat (2) @(negedge clk);
    apply(1'b1, "R9 re-enabled");
    chk("R9 re-enabled elim", 1, 32'(out_src1_elim[1]), 32'h1);

    // random sweep with enable on, then off, then on again
    for (int n = 0; n < 2000; n++) begin gen_group(); apply(1'b1, "rand en"); end
    csr_write(12'h5C4, 64'h2);
    repeat (2) @(negedge clk);
    for (int n = 0; n < 800; n++) begin gen_group(); apply(1'b0, "rand dis"); end
    csr_write(12'h5C4, 64'h1);
    repeat (2) @(negedge clk);
    for (int n = 0; n < 400; n++) begin gen_group(); apply(1'b1, "rand en2"); end

    finish_run();
  end
endmodule